// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit multiplying DAC. It holds the code that drives the converter in two stages. A staging latch has two independent sections: an 8-bit upper part and a 4-bit lower part. An output register holds the code actually presented to the converter.

A host on an 8-bit bus loads a full code in two writes. First it writes with the byte-select high, which loads all twelve bits. Then it writes with the byte-select low, which refreshes only the low nibble. A separate transfer strobe pair then copies all twelve bits into the output register at once. Because of this, a multi-byte load never shows a partial code at the output.

The strobes are level-sensitive. A stage follows its inputs on every clock while its enable condition holds, and it keeps its value once the condition is removed. The design samples the strobes on the block clock. When both stages are open, data flows straight through the staging latch into the output register.

Top module: `dac_dbuf_reg`

## Requirements
- R1: An active-low reset `rst_n` clears both the staging latch and the output register, so `code` reads 0 and a later transfer with no write in between also gives 0.
- R2: While `cs_n` is high, a low `wr1_n` has no effect on the staging latch.
- R3: While `wr1_n` is high, the staging latch keeps its contents whatever `din` does.
- R4: With `cs_n` and `wr1_n` low and `byte_all` high, all 12 staging bits take `din` at each clock edge.
- R5: With `cs_n` and `wr1_n` low and `byte_all` low, only staging bits 3..0 take `din[3:0]`, and bits 11..4 are unchanged.
- R6: The output register loads the staging contents only at an edge where both `wr2_n` and `xfer_n` are low; `cs_n` plays no part in this. If either strobe is high, `code` holds its value.
- R7: When `cs_n`, `wr1_n`, `wr2_n` and `xfer_n` are all low at an edge, `code` takes the newly written staging value at that same edge (flow-through). Only the low nibble is new when `byte_all` is low.
- R8: `code` bit 0 is the least significant bit and bit 11 the most significant; `din` maps bit for bit. The all-ones code 4095 is full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both stages |
| cs_n | input | 1 | Active-low select qualifying the first-stage write |
| wr1_n | input | 1 | Active-low first-stage write strobe |
| byte_all | input | 1 | High: write all 12 bits; low: write only the low nibble |
| wr2_n | input | 1 | Active-low enable for the transfer |
| xfer_n | input | 1 | Active-low transfer strobe |
| din | input | 12 | Data in, bit 0 least significant |
| code | output | 12 | Code held by the output register |

## Verification
Every result appears on `code` exactly one clock edge after the strobes and data that cause it are sampled. This holds for a transfer, for the flow-through path and for reset release. A write to the staging latch is not visible on its own; it shows only after a later transfer.

The bench drives inputs on the falling edge. At the next rising edge it advances a behavioural model. It compares `code` with the model on the following falling edge, one edge after the stimulus. Staging-only effects are therefore checked by the value that a later transfer produces.

// File: rtl/dac_dbuf_reg.sv
module dac_dbuf_reg #(
  parameter int CODE_W = 12,
  parameter int LO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr1_n,
  input  logic              byte_all,
  input  logic              wr2_n,
  input  logic              xfer_n,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code
);
  localparam int HI_W = CODE_W - LO_W;

  logic [HI_W-1:0]   stg_hi, stg_hi_nx;
  logic [LO_W-1:0]   stg_lo, stg_lo_nx;
  logic [CODE_W-1:0] code_q;
  logic              wr_en, xfer_en;

  assign wr_en     = !cs_n && !wr1_n;
  assign xfer_en   = !wr2_n && !xfer_n;
  assign stg_hi_nx = (wr_en && byte_all) ? din[CODE_W-1:LO_W] : stg_hi;
  assign stg_lo_nx = wr_en ? din[LO_W-1:0] : stg_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_hi <= '0;
      stg_lo <= '0;
      code_q <= '0;
    end else begin
      stg_hi <= stg_hi_nx;
      stg_lo <= stg_lo_nx;
      if (xfer_en) code_q <= {stg_hi_nx, stg_lo_nx};
    end
  end

  assign code = code_q;
endmodule

module dac_dbuf_reg_chk #(
  parameter int CODE_W = 12,
  parameter int LO_W   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   wr1_n,
  input logic                   byte_all,
  input logic                   wr2_n,
  input logic                   xfer_n,
  input logic [CODE_W-1:0]      din,
  input logic [CODE_W-1:0]      code,
  input logic [CODE_W-LO_W-1:0] stg_hi,
  input logic [LO_W-1:0]        stg_lo
);
  a_r2_cs_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(stg_hi) && $stable(stg_lo)));

  a_r3_wr1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_n |=> ($stable(stg_hi) && $stable(stg_lo)));

  a_r4_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr1_n && byte_all) |=> ({stg_hi, stg_lo} == $past(din)));

  a_r5_nibble_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr1_n && !byte_all) |=>
      ($stable(stg_hi) && stg_lo == $past(din[LO_W-1:0])));

  a_r6_no_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr2_n || xfer_n) |=> $stable(code));

  a_r6_xfer_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr2_n && !xfer_n) |=> (code == {stg_hi, stg_lo}));

  a_r7_flow_through: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr1_n && byte_all && !wr2_n && !xfer_n) |=> (code == $past(din)));
endmodule

bind dac_dbuf_reg dac_dbuf_reg_chk #(.CODE_W(CODE_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr1_n(wr1_n), .byte_all(byte_all),
  .wr2_n(wr2_n), .xfer_n(xfer_n), .din(din), .code(code),
  .stg_hi(stg_hi), .stg_lo(stg_lo)
);

// File: tb/test_dac_dbuf_reg.sv
module test_dac_dbuf_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr1_n = 1'b1, byte_all = 1'b1;
  logic        wr2_n = 1'b1, xfer_n = 1'b1;
  logic [11:0] din = '0;
  logic [11:0] code;

  int checks = 0;
  int errors = 0;
  int m_hi = 0, m_lo = 0, m_code = 0;

  always #2 clk = ~clk;

  dac_dbuf_reg i_dac_dbuf_reg (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr1_n(wr1_n), .byte_all(byte_all),
    .wr2_n(wr2_n), .xfer_n(xfer_n), .din(din), .code(code)
  );

  task automatic check(input string tag, input int exp);
    checks++;
    if (int'(code) != exp) begin
      errors++;
      $display("FAIL %s code=%0h expected=%0h", tag, code, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit w1, input bit ba, input bit w2,
                     input bit xf, input int d, input string tag);
    cs_n = c; wr1_n = w1; byte_all = ba; wr2_n = w2; xfer_n = xf;
    din = 12'(d);
    @(posedge clk);
    if (!c && !w1) begin
      if (ba) m_hi = (d >> 4) & 255;
      m_lo = d & 15;
    end
    if (!w2 && !xf) m_code = m_hi * 16 + m_lo;
    @(negedge clk);
    check(tag, m_code);
  endtask

  task automatic do_reset();
    cs_n = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1;
    rst_n = 0;
    repeat (2) @(negedge clk);
    m_hi = 0; m_lo = 0; m_code = 0;
    check("R1 reset", 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog code=%0h expected=done", code);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    cyc(1,1,1,0,0, 12'h000, "R1 transfer after reset");
    cyc(0,0,1,1,1, 12'hABC, "R4 full write, R6 no transfer");
    cyc(0,0,0,1,1, 12'hFF5, "R5 nibble write, R6 no transfer");
    cyc(1,1,1,0,1, 12'h000, "R6 wr2 only");
    cyc(1,1,1,1,0, 12'h000, "R6 xfer only");
    cyc(1,1,1,0,0, 12'h000, "R5 R6 transfer gives AB5");
    cyc(1,0,1,1,1, 12'h123, "R2 write with cs high");
    cyc(1,1,1,0,0, 12'h000, "R2 transfer after ignored write");
    cyc(0,1,1,1,1, 12'h456, "R3 wr1 high");
    cyc(0,1,1,0,0, 12'h789, "R3 R6 transfer with cs low");
    cyc(0,0,1,0,0, 12'hFFF, "R7 R8 flow-through full scale");
    cyc(0,0,1,0,0, 12'h001, "R7 R8 flow-through LSB");
    cyc(0,0,1,0,0, 12'h800, "R8 MSB");
    cyc(0,0,0,0,0, 12'h7E2, "R7 flow-through nibble only");
    cyc(0,0,1,1,1, 12'h3C3, "R4 stage");
    do_reset();
    cyc(1,1,1,0,0, 12'h000, "R1 latch cleared by reset");
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom);
      cyc(r[0], r[1], r[2], r[3] & r[5], r[4] & r[6], (r >> 8) & 4095, "R2 R3 R4 R5 R6 R7 mixed");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule